// File: doc/BRIEF.md
# Leveled Interrupt Pending Register Bank

This block holds interrupt requests grouped into priority levels. Each level keeps a 64-bit pending word, one bit per source. Agents raise and drop requests with post and clear commands, and each command names a level and a source index. A clear-all command wipes the whole bank. The block keeps a summary vector with one bit per level for the priority logic that follows it. It also gives an any-pending flag and a combinational query of whether a chosen level has work.

The summary bit of a level is set on every accepted post. A clear drops that bit only when the clear removes the last pending source of the level. A command that names a level the bank does not have, or a source index of 64 or more, changes no state. Such a command raises a single-cycle error pulse. Reset is synchronous and active-low.

Top module: `irq_pend_bank`

## Requirements
- R1: While `rst_n` is low at a clock edge, every pending word and `lvl_pend` are zeroed and `cmd_err` is driven low; after reset `any_pend` and `qry_hit` read 0.
- R2: A legal post (level below NUM_LVL, index below 64) sets bit `post_idx` of that level's word and sets `lvl_pend[post_lvl]` at the next clock edge.
- R3: A legal clear removes bit `clr_idx` from that level's word at the next edge; `lvl_pend` for that level falls only if the word is then all zero, and stays set otherwise.
- R4: A clear-all zeroes every word and `lvl_pend` at the next edge and overrides any post or clear in the same cycle.
- R5: `qry_hit` is 1 exactly when `qry_lvl` names an implemented level whose pending word is nonzero; it follows `qry_lvl` combinationally and reads 0 for `qry_lvl >= NUM_LVL`.
- R6: `any_pend` is 1 exactly when at least one bit of `lvl_pend` is set.
- R7: A post or clear with level >= NUM_LVL or index >= 64 leaves every word and `lvl_pend` unchanged.
- R8: `cmd_err` is high for exactly the one cycle after a cycle that carried at least one illegal post or clear, and is low otherwise.
- R9: A post and a clear to the same level and index in the same cycle leave that bit set: the post wins.
- R10: A legal post and a legal clear in the same cycle to different levels, or to different bits of one level, both take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| post_vld | input | 1 | Post command valid |
| post_lvl | input | LVL_W | Level of the post |
| post_idx | input | 7 | Source index of the post |
| clr_vld | input | 1 | Clear command valid |
| clr_lvl | input | LVL_W | Level of the clear |
| clr_idx | input | 7 | Source index of the clear |
| clr_all | input | 1 | Wipe the whole bank |
| qry_lvl | input | LVL_W | Level being queried |
| qry_hit | output | 1 | Queried level has a pending source |
| lvl_pend | output | NUM_LVL | Per-level summary vector |
| any_pend | output | 1 | Any level pending |
| cmd_err | output | 1 | Illegal command seen the previous cycle |

## Verification
A pending word that has taken a wrong bit has no port of its own. It shows up one edge later as a wrong `lvl_pend` bit, or later still when a clear fails to drop the summary. For that reason each scenario ends by clearing down to an empty level and checking that the summary falls on the very edge of the last clear. A summary bit that lags or leads its word shows up at once on `qry_hit` and `any_pend`. A misclassified command shows on `cmd_err` one cycle after it is issued.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int unsigned SRC_W = 64;
  localparam int unsigned IDX_W = $clog2(SRC_W) + 1;

  // index is legal when it falls inside the pending word
  function automatic logic idx_legal(logic [IDX_W-1:0] idx);
    return idx < IDX_W'(SRC_W);
  endfunction

  // one-hot source mask; all zero for an illegal index
  function automatic logic [SRC_W-1:0] src_mask(logic [IDX_W-1:0] idx);
    logic [SRC_W-1:0] m;
    m = '0;
    if (idx_legal(idx)) m[idx[IDX_W-2:0]] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irq_cmd_decode.sv
module irq_cmd_decode
  import irq_bank_pkg::*;
#(
  parameter int unsigned NUM_LVL = 8,
  parameter int unsigned LVL_W   = $clog2(NUM_LVL) + 1
) (
  input  logic               vld,
  input  logic [LVL_W-1:0]   lvl,
  input  logic [IDX_W-1:0]   idx,
  output logic               ok,
  output logic               bad,
  output logic [NUM_LVL-1:0] sel,
  output logic [SRC_W-1:0]   mask
);
  logic lvl_in_range;

  assign lvl_in_range = lvl < LVL_W'(NUM_LVL);
  assign ok   = vld && lvl_in_range && idx_legal(idx);
  assign bad  = vld && !ok;
  assign mask = src_mask(idx);

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_sel
    assign sel[g] = ok && (lvl == LVL_W'(g));
  end
endmodule

// File: rtl/irq_level_slot.sv
module irq_level_slot
  import irq_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wipe,
  input  logic             set_hit,
  input  logic [SRC_W-1:0] set_mask,
  input  logic             drop_hit,
  input  logic [SRC_W-1:0] drop_mask,
  output logic [SRC_W-1:0] word,
  output logic             summ
);
  logic [SRC_W-1:0] after_drop;
  logic [SRC_W-1:0] word_nxt;
  logic             summ_nxt;

  always_comb begin
    after_drop = drop_hit ? (word & ~drop_mask) : word;
    word_nxt   = set_hit ? (after_drop | set_mask) : after_drop;
    if (set_hit)       summ_nxt = 1'b1;
    else if (drop_hit) summ_nxt = |word_nxt;
    else               summ_nxt = summ;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || wipe) begin
      word <= '0;
      summ <= 1'b0;
    end else begin
      word <= word_nxt;
      summ <= summ_nxt;
    end
  end
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
  import irq_bank_pkg::*;
#(
  parameter int unsigned NUM_LVL = 8,
  localparam int unsigned LVL_W  = $clog2(NUM_LVL) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               post_vld,
  input  logic [LVL_W-1:0]   post_lvl,
  input  logic [IDX_W-1:0]   post_idx,
  input  logic               clr_vld,
  input  logic [LVL_W-1:0]   clr_lvl,
  input  logic [IDX_W-1:0]   clr_idx,
  input  logic               clr_all,
  input  logic [LVL_W-1:0]   qry_lvl,
  output logic               qry_hit,
  output logic [NUM_LVL-1:0] lvl_pend,
  output logic               any_pend,
  output logic               cmd_err
);
  // named internal events for the checker
  logic               post_ok, post_bad, clr_ok, clr_bad;
  logic [NUM_LVL-1:0] post_sel, clr_sel;
  logic [SRC_W-1:0]   post_mask, clr_mask;
  logic [NUM_LVL-1:0] lvl_nz;
  logic [NUM_LVL-1:0] qry_match;

  irq_cmd_decode #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_post_dec (
    .vld(post_vld), .lvl(post_lvl), .idx(post_idx),
    .ok(post_ok), .bad(post_bad), .sel(post_sel), .mask(post_mask)
  );

  irq_cmd_decode #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_clr_dec (
    .vld(clr_vld), .lvl(clr_lvl), .idx(clr_idx),
    .ok(clr_ok), .bad(clr_bad), .sel(clr_sel), .mask(clr_mask)
  );

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    logic [SRC_W-1:0] word;
    irq_level_slot u_slot (
      .clk(clk), .rst_n(rst_n), .wipe(clr_all),
      .set_hit(post_sel[g]), .set_mask(post_mask),
      .drop_hit(clr_sel[g]), .drop_mask(clr_mask),
      .word(word), .summ(lvl_pend[g])
    );
    assign lvl_nz[g]    = |word;
    assign qry_match[g] = (qry_lvl == LVL_W'(g));
  end

  assign qry_hit  = |(qry_match & lvl_nz);
  assign any_pend = |lvl_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) cmd_err <= 1'b0;
    else        cmd_err <= post_bad || clr_bad;
  end
endmodule

// File: rtl/irq_pend_bank_chk.sv
module irq_pend_bank_chk #(
  parameter int unsigned NUM_LVL = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               clr_vld,
  input logic               clr_all,
  input logic               post_ok,
  input logic               post_bad,
  input logic               clr_bad,
  input logic [NUM_LVL-1:0] post_sel,
  input logic [NUM_LVL-1:0] lvl_pend,
  input logic               any_pend,
  input logic               qry_hit,
  input logic               cmd_err
);
  assert_err_follows_bad_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (post_bad || clr_bad) |=> cmd_err);

  assert_err_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(post_bad || clr_bad) |=> !cmd_err);

  assert_wipe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (lvl_pend == '0));

  assert_post_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (post_ok && !clr_all) |=> ((lvl_pend & $past(post_sel)) == $past(post_sel)));

  assert_no_rise_without_post_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !post_ok |=> ((lvl_pend & ~$past(lvl_pend)) == '0));

  assert_bad_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (post_bad && !clr_vld && !clr_all) |=> $stable(lvl_pend));

  assert_idle_query_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !any_pend |-> !qry_hit);
endmodule

bind irq_pend_bank irq_pend_bank_chk #(.NUM_LVL(NUM_LVL)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_vld(clr_vld), .clr_all(clr_all),
  .post_ok(post_ok), .post_bad(post_bad), .clr_bad(clr_bad),
  .post_sel(post_sel), .lvl_pend(lvl_pend), .any_pend(any_pend),
  .qry_hit(qry_hit), .cmd_err(cmd_err)
);

// File: tb/test_irq_pend_bank.sv
`timescale 1ns/1ps
module test_irq_pend_bank;
  localparam int NL  = 8;
  localparam int LW  = $clog2(NL) + 1;
  localparam int IW  = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic post_vld = 0, clr_vld = 0, clr_all = 0;
  logic [LW-1:0] post_lvl = '0, clr_lvl = '0, qry_lvl = '0;
  logic [IW-1:0] post_idx = '0, clr_idx = '0;
  logic qry_hit, any_pend, cmd_err;
  logic [NL-1:0] lvl_pend;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    string         tag;
    logic [NL-1:0] pend;
    logic          any;
    logic          hit;
    logic          err;
  } exp_t;
  exp_t exp_q[$];

  logic [63:0] mdl [NL];

  always #2 clk = ~clk;

  irq_pend_bank #(.NUM_LVL(NL)) i_irq_pend_bank (
    .clk(clk), .rst_n(rst_n),
    .post_vld(post_vld), .post_lvl(post_lvl), .post_idx(post_idx),
    .clr_vld(clr_vld), .clr_lvl(clr_lvl), .clr_idx(clr_idx),
    .clr_all(clr_all), .qry_lvl(qry_lvl), .qry_hit(qry_hit),
    .lvl_pend(lvl_pend), .any_pend(any_pend), .cmd_err(cmd_err)
  );

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: applies one command cycle and pushes the expected outcome
  task automatic step(string tag, bit pv, int pl, int pi, bit cv, int cl, int ci,
                      bit ca, int ql);
    exp_t e;
    bit pok, cok;
    @(negedge clk);
    post_vld = pv; post_lvl = LW'(pl); post_idx = IW'(pi);
    clr_vld  = cv; clr_lvl  = LW'(cl); clr_idx  = IW'(ci);
    clr_all  = ca; qry_lvl  = LW'(ql);
    pok = pv && pl < NL && pi < 64;
    cok = cv && cl < NL && ci < 64;
    if (ca) begin
      for (int k = 0; k < NL; k++) mdl[k] = '0;
    end else begin
      if (cok) mdl[cl][ci] = 1'b0;
      if (pok) mdl[pl][pi] = 1'b1;   // post applied last: it wins
    end
    e.tag = tag;
    e.pend = '0;
    for (int k = 0; k < NL; k++) e.pend[k] = (mdl[k] != 0);
    e.any = (e.pend != 0);
    e.hit = (ql < NL) ? (mdl[ql] != 0) : 1'b0;
    e.err = (pv && !pok) || (cv && !cok);
    exp_q.push_back(e);
  endtask

  // monitor: compares after the edge that registers each command
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(e.tag, "lvl_pend", 64'(lvl_pend), 64'(e.pend));
      check(e.tag, "any_pend R6", 64'(any_pend), 64'(e.any));
      check(e.tag, "qry_hit R5", 64'(qry_hit), 64'(e.hit));
      check(e.tag, "cmd_err R8", 64'(cmd_err), 64'(e.err));
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #40000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    for (int k = 0; k < NL; k++) mdl[k] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "lvl_pend", 64'(lvl_pend), 64'(0));
    check("R1", "any_pend", 64'(any_pend), 64'(0));
    check("R1", "qry_hit", 64'(qry_hit), 64'(0));
    check("R1", "cmd_err", 64'(cmd_err), 64'(0));
    rst_n = 1'b1;

    step("R2", 1, 3, 5,  0, 0, 0,  0, 3);
    step("R2", 1, 3, 63, 0, 0, 0,  0, 3);
    step("R5", 0, 0, 0,  0, 0, 0,  0, 2);
    step("R3", 0, 0, 0,  1, 3, 5,  0, 3);   // bit63 remains: summary stays
    step("R3", 0, 0, 0,  1, 3, 63, 0, 3);   // last source: summary falls
    step("R3", 0, 0, 0,  1, 4, 9,  0, 4);   // clear of empty level
    step("R7", 1, 9, 1,  0, 0, 0,  0, 1);   // level out of range
    step("R8", 0, 0, 0,  0, 0, 0,  0, 1);   // pulse lasts one cycle
    step("R7", 1, 1, 64, 0, 0, 0,  0, 1);   // index out of range
    step("R2", 1, 0, 0,  0, 0, 0,  0, 0);
    step("R7", 0, 0, 0,  1, 0, 70, 0, 0);   // illegal clear keeps level 0
    step("R7", 0, 0, 0,  1, 12, 0, 0, 0);
    step("R9", 1, 0, 2,  1, 0, 2,  0, 0);   // post wins
    step("R3", 0, 0, 0,  1, 0, 0,  0, 0);   // bit2 still holds level 0
    step("R10", 1, 7, 10, 1, 0, 2, 0, 7);   // both take effect
    step("R10", 1, 7, 11, 1, 7, 10, 0, 7);  // different bits, same level
    step("R6", 1, 5, 0,  0, 0, 0,  0, 5);
    step("R5", 0, 0, 0,  0, 0, 0,  0, 12);  // query out of range
    step("R4", 1, 1, 1,  1, 7, 11, 1, 1);   // wipe overrides both
    step("R6", 0, 0, 0,  0, 0, 0,  0, 0);
    step("R8", 1, 15, 0, 1, 2, 99, 0, 2);   // both illegal: one pulse
    step("R8", 0, 0, 0,  0, 0, 0,  0, 2);

    @(negedge clk);
    post_vld = 0; clr_vld = 0; clr_all = 0;
    repeat (3) @(posedge clk);
    #2;
    finish_run();
  end
endmodule